// File: doc/BRIEF.md
# Coprocessor Operand Bus-Master Unit

This unit sits beside a coprocessor that watches a bus it shares with a host CPU. It moves memory operands wider than one 16-bit word. The instruction decoder first hands it a command giving the operand length and whether the operand is read from memory (load) or written to it (store).

The host then performs one ordinary read cycle for the instruction. During that cycle the unit takes the address on the bus as the operand's base address. For a load it also keeps the data word that comes back, as the operand's first word. For a store it throws that word away. The unit then asks for the bus and, once granted, moves the rest of the operand over its own master port at consecutive word addresses. It gives the bus back in the cycle the final word completes.

A single pulse marks the end of each operand. It carries the assembled 80-bit operand buffer. Arithmetic and instruction decoding belong to other blocks.

Top module: `opnd_mover`

## Requirements
- R1: While `rstN` is low and after reset, `busReq`, `mRd`, `mWr` and `opDone` are low.
- R2: A host read cycle (`hostRd` and `hostDone` high in the same cycle) that occurs while a command is pending latches `hostAddr` as the base. Operand word i is accessed at base + 2*i, modulo 2^20.
- R3: On a load (`cmdStore`=0), the `hostData` word of that host cycle becomes operand word 0. Word i of the operand sits at `opData[16*i+15:16*i]`.
- R4: On a multi-word load, words 1 to N-1 are read over the master port in increasing address order. Each one is stored as operand word i. N is `cmdWords`, one of 1, 2, 4 or 5.
- R5: On a store (`cmdStore`=1), the `hostData` of the host cycle is ignored. All N words of `storeData` are written over the master port in increasing address order, starting at word 0 on the base address.
- R6: `busReq` rises in the cycle after the host read cycle when master transfers are needed. `mRd` and `mWr` are never high while `busGnt` is low, and never both high at once.
- R7: `busReq` falls in the same cycle in which `mDone` completes the last word, and stays low at `opDone`.
- R8: A one-word load makes no bus request, and `opDone` is high in the cycle right after the host read cycle.
- R9: `opDone` is a one-cycle pulse. On a load, `opData` holds the words read, with every word at or above N equal to zero. On a store, `opData` holds `storeData`.
- R10: A host read cycle while no command is pending has no effect: no request and no `opDone`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Decoder command strobe |
| cmdWords | input | 3 | Operand length in words (1, 2, 4, 5) |
| cmdStore | input | 1 | 1 = store to memory, 0 = load |
| storeData | input | 80 | Operand to store, word i in bits 16i+15:16i |
| hostAddr | input | 20 | Host bus address |
| hostData | input | 16 | Host bus read data |
| hostRd | input | 1 | Host read cycle in progress |
| hostDone | input | 1 | Host cycle completes this clock |
| busReq | output | 1 | Bus mastership request |
| busGnt | input | 1 | Bus mastership grant |
| mAddr | output | 20 | Master port byte address |
| mWrData | output | 16 | Master port write data |
| mRdData | input | 16 | Master port read data |
| mRd | output | 1 | Master read strobe |
| mWr | output | 1 | Master write strobe |
| mDone | input | 1 | Master access completes this clock |
| opDone | output | 1 | Operand complete pulse |
| opData | output | 80 | Assembled operand buffer |

## Verification
The bench sweeps each of the four lengths in both directions. It uses base addresses in low memory, at an arbitrary mid value, and just below the top of the 20-bit space, so that the word addresses wrap. Each combination runs with both an immediate and a delayed grant, and with fast and slow memory acknowledges. Memory contents and store patterns come from address and index arithmetic. The load sweep therefore shows whether word 0 came from the host cycle or from a bus read, and catches words placed at the wrong index. The store sweep shows whether the host's read data leaks into the written words. A host read with no command pending, and the one-word load that needs no bus, check the paths where the master port must stay silent.

// File: rtl/opnd_mover_pkg.sv
package opnd_mover_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARMED,
    ST_REQ,
    ST_XFER,
    ST_FIN
  } stateT;

  typedef struct packed {
    logic loadCmd;
    logic captureHost;
    logic captureBus;
  } strobeT;

endpackage

// File: rtl/opnd_mover_ctrl.sv
module opnd_mover_ctrl
  import opnd_mover_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   cmdValid,
  input  logic   hostRd,
  input  logic   hostDone,
  input  logic   busGnt,
  input  logic   mDone,
  input  logic   isStore,
  input  logic   singleWord,
  input  logic   lastWord,
  output strobeT strobe,
  output logic   busReq,
  output logic   mRd,
  output logic   mWr,
  output logic   opDone
);

  stateT state, nextState;
  logic  drive;
  logic  finalBeat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign drive     = (state == ST_XFER) && busGnt;
  assign finalBeat = drive && mDone && lastWord;

  always_comb begin
    nextState = state;
    strobe    = '0;
    busReq    = 1'b0;
    mRd       = 1'b0;
    mWr       = 1'b0;
    opDone    = 1'b0;
    case (state)
      ST_IDLE: begin
        if (cmdValid) begin
          strobe.loadCmd = 1'b1;
          nextState      = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (hostRd && hostDone) begin
          strobe.captureHost = 1'b1;
          nextState = (!isStore && singleWord) ? ST_FIN : ST_REQ;
        end
      end
      ST_REQ: begin
        busReq = 1'b1;
        if (busGnt) nextState = ST_XFER;
      end
      ST_XFER: begin
        busReq = !finalBeat;
        mRd    = drive && !isStore;
        mWr    = drive && isStore;
        if (drive && mDone) begin
          strobe.captureBus = 1'b1;
          if (lastWord) nextState = ST_FIN;
        end
      end
      ST_FIN: begin
        opDone    = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/opnd_mover_datapath.sv
module opnd_mover_datapath
  import opnd_mover_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 5,
  localparam int IDX_W    = $clog2(MAX_WORDS + 1),
  localparam int BUF_W    = DATA_W * MAX_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobe,
  input  logic [IDX_W-1:0]  cmdWords,
  input  logic              cmdStore,
  input  logic [BUF_W-1:0]  storeData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic [DATA_W-1:0] mRdData,
  output logic              isStore,
  output logic              singleWord,
  output logic              lastWord,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWrData,
  output logic [BUF_W-1:0]  opData
);

  logic [ADDR_W-1:0] baseAddr;
  logic [IDX_W-1:0]  wordCount;
  logic [IDX_W-1:0]  wordIdx;
  logic              storeDir;
  logic [DATA_W-1:0] bufWords [MAX_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseAddr  <= '0;
      wordCount <= IDX_W'(1);
      wordIdx   <= '0;
      storeDir  <= 1'b0;
    end else begin
      if (strobe.loadCmd) begin
        wordCount <= cmdWords;
        storeDir  <= cmdStore;
      end
      if (strobe.captureHost) begin
        baseAddr <= hostAddr;
        wordIdx  <= storeDir ? '0 : IDX_W'(1);
      end
      if (strobe.captureBus) wordIdx <= wordIdx + IDX_W'(1);
    end
  end

  for (genvar i = 0; i < MAX_WORDS; i++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufWords[i] <= '0;
      end else if (strobe.loadCmd) begin
        bufWords[i] <= cmdStore ? storeData[i*DATA_W +: DATA_W] : '0;
      end else if (strobe.captureHost && !storeDir && i == 0) begin
        bufWords[i] <= hostData;
      end else if (strobe.captureBus && !storeDir && wordIdx == IDX_W'(i)) begin
        bufWords[i] <= mRdData;
      end
    end
    assign opData[i*DATA_W +: DATA_W] = bufWords[i];
  end

  assign isStore    = storeDir;
  assign singleWord = (wordCount == IDX_W'(1));
  assign lastWord   = (wordIdx == wordCount - IDX_W'(1));
  assign mAddr      = baseAddr + (ADDR_W'(wordIdx) << 1);
  assign mWrData    = bufWords[wordIdx];

endmodule

// File: rtl/opnd_mover.sv
module opnd_mover
  import opnd_mover_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int MAX_WORDS = 5,
  localparam int IDX_W    = $clog2(MAX_WORDS + 1),
  localparam int BUF_W    = DATA_W * MAX_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [IDX_W-1:0]  cmdWords,
  input  logic              cmdStore,
  input  logic [BUF_W-1:0]  storeData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostData,
  input  logic              hostRd,
  input  logic              hostDone,
  output logic              busReq,
  input  logic              busGnt,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mWrData,
  input  logic [DATA_W-1:0] mRdData,
  output logic              mRd,
  output logic              mWr,
  input  logic              mDone,
  output logic              opDone,
  output logic [BUF_W-1:0]  opData
);

  strobeT strobe;
  logic   isStore, singleWord, lastWord;

  opnd_mover_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .hostRd(hostRd),
    .hostDone(hostDone), .busGnt(busGnt), .mDone(mDone),
    .isStore(isStore), .singleWord(singleWord), .lastWord(lastWord),
    .strobe(strobe), .busReq(busReq), .mRd(mRd), .mWr(mWr), .opDone(opDone)
  );

  opnd_mover_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_WORDS(MAX_WORDS)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmdWords(cmdWords),
    .cmdStore(cmdStore), .storeData(storeData), .hostAddr(hostAddr),
    .hostData(hostData), .mRdData(mRdData), .isStore(isStore),
    .singleWord(singleWord), .lastWord(lastWord), .mAddr(mAddr),
    .mWrData(mWrData), .opData(opData)
  );

endmodule

// File: rtl/opnd_mover_chk.sv
module opnd_mover_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rstN,
  input logic              busReq,
  input logic              busGnt,
  input logic              mRd,
  input logic              mWr,
  input logic              mDone,
  input logic [ADDR_W-1:0] mAddr,
  input logic              opDone
);

  always @(posedge clk) begin
    if (!rstN) begin
      AST_QUIET_IN_RESET: assert (!busReq && !mRd && !mWr && !opDone); // R1
    end
  end

  AST_DRIVE_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rstN)
    (mRd || mWr) |-> busGnt); // R6

  AST_ONE_DIRECTION: assert property (@(posedge clk) disable iff (!rstN)
    !(mRd && mWr)); // R6

  AST_DONE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |=> !opDone); // R9

  AST_RELEASED_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    opDone |-> !busReq); // R7

  AST_ADDR_STRIDE: assert property (@(posedge clk) disable iff (!rstN)
    ($past((mRd || mWr) && mDone) && (mRd || mWr))
      |-> (mAddr == $past(mAddr) + ADDR_W'(2))); // R2

endmodule

bind opnd_mover opnd_mover_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .busReq(busReq), .busGnt(busGnt), .mRd(mRd),
  .mWr(mWr), .mDone(mDone), .mAddr(mAddr), .opDone(opDone)
);

// File: tb/opnd_mover_test.sv
`timescale 1ns/1ps
module opnd_mover_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdValid = 1'b0;
  logic [2:0]  cmdWords = 3'd1;
  logic        cmdStore = 1'b0;
  logic [79:0] storeData = '0;
  logic [19:0] hostAddr = '0;
  logic [15:0] hostData = '0;
  logic        hostRd = 1'b0;
  logic        hostDone = 1'b0;
  logic        busReq;
  logic        busGnt = 1'b0;
  logic [19:0] mAddr;
  logic [15:0] mWrData;
  logic [15:0] mRdData;
  logic        mRd, mWr;
  logic        mDone = 1'b0;
  logic        opDone;
  logic [79:0] opData;

  int vectors = 0;
  int fails = 0;
  int gntDelay = 0;
  int waitCfg = 0;
  int gCnt = 0;
  int wCnt = 0;
  int xferCnt = 0;
  int curWords = 1;
  logic curStore = 1'b0;
  logic [19:0] curBase = '0;
  logic reqSeen = 1'b0;

  always #5 clk = ~clk;

  opnd_mover uut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdWords(cmdWords),
    .cmdStore(cmdStore), .storeData(storeData), .hostAddr(hostAddr),
    .hostData(hostData), .hostRd(hostRd), .hostDone(hostDone),
    .busReq(busReq), .busGnt(busGnt), .mAddr(mAddr), .mWrData(mWrData),
    .mRdData(mRdData), .mRd(mRd), .mWr(mWr), .mDone(mDone),
    .opDone(opDone), .opData(opData)
  );

  function automatic logic [15:0] memWord(input logic [19:0] a);
    return (a[15:0] * 16'd37) ^ {12'hA5C, a[19:16]};
  endfunction

  function automatic logic [15:0] stWord(input logic [19:0] b, input int i);
    return b[15:0] + 16'h1111 * 16'(i + 1) ^ 16'h0F00;
  endfunction

  assign mRdData = memWord(mAddr);

  task automatic check(input logic ok, input string tag,
                       input logic [79:0] act, input logic [79:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus arbiter model
  always @(posedge clk) begin
    if (!busReq) begin
      busGnt <= 1'b0;
      gCnt   <= 0;
    end else if (gCnt >= gntDelay) begin
      busGnt <= 1'b1;
    end else begin
      gCnt <= gCnt + 1;
    end
  end

  // memory responder model
  always @(posedge clk) begin
    if (mDone) begin
      mDone <= 1'b0;
    end else if (mRd || mWr) begin
      if (wCnt >= waitCfg) begin
        mDone <= 1'b1;
        wCnt  <= 0;
      end else begin
        wCnt <= wCnt + 1;
      end
    end
  end

  // port monitor
  always @(negedge clk) begin
    if (rstN) begin
      if (busReq) reqSeen <= 1'b1;
      if ((mRd || mWr) && !busGnt)
        check(1'b0, "R6 master driven without grant", 80'(mRd), 80'(0));
      if (mRd && mWr)
        check(1'b0, "R6 read and write together", 80'(1), 80'(0));
      if ((mRd || mWr) && mDone) begin
        automatic int idx = curStore ? xferCnt : xferCnt + 1;
        automatic logic [19:0] expA = curBase + 20'(2 * idx);
        automatic int lastCnt = curStore ? curWords - 1 : curWords - 2;
        check(mAddr == expA, "R2 master address", 80'(mAddr), 80'(expA));
        check(mRd == !curStore, "R4/R5 transfer direction", 80'(mRd), 80'(!curStore));
        if (mWr)
          check(mWrData == stWord(curBase, idx), "R5 write data",
                80'(mWrData), 80'(stWord(curBase, idx)));
        if (xferCnt == lastCnt)
          check(!busReq, "R7 request drops on last word", 80'(busReq), 80'(0));
        else
          check(busReq, "R7 request held mid transfer", 80'(busReq), 80'(1));
        xferCnt <= xferCnt + 1;
      end
    end
  end

  task automatic runOp(input int words, input logic store, input logic [19:0] base);
    logic [79:0] expData;
    logic [79:0] sd;
    int guard;
    int expXfers;
    sd = '0;
    for (int i = 0; i < 5; i++) sd[16*i +: 16] = stWord(base, i);
    expData = '0;
    if (store) expData = sd;
    else begin
      expData[15:0] = base[15:0] ^ 16'h3C3C;
      for (int i = 1; i < words; i++) expData[16*i +: 16] = memWord(base + 20'(2 * i));
    end
    expXfers = store ? words : words - 1;

    @(negedge clk);
    curWords  = words;
    curStore  = store;
    curBase   = base;
    xferCnt   = 0;
    reqSeen   = 1'b0;
    cmdValid  = 1'b1;
    cmdWords  = 3'(words);
    cmdStore  = store;
    storeData = sd;
    @(negedge clk);
    cmdValid = 1'b0;
    storeData = ~sd;
    repeat (2) @(negedge clk);
    hostAddr = base;
    hostData = store ? (16'hDEAD ^ base[15:0]) : (base[15:0] ^ 16'h3C3C);
    hostRd   = 1'b1;
    @(negedge clk);
    hostDone = 1'b1;
    @(negedge clk);
    hostRd   = 1'b0;
    hostDone = 1'b0;
    hostAddr = 20'h5A5A5;
    hostData = 16'hFFFF;
    if (!store && words == 1) begin
      check(opDone, "R8 one-word load done next cycle", 80'(opDone), 80'(1));
      check(!busReq && !reqSeen, "R8 no request on one-word load",
            80'(reqSeen | busReq), 80'(0));
    end else begin
      check(busReq, "R6 request after host cycle", 80'(busReq), 80'(1));
      guard = 0;
      while (!opDone && guard < 200) begin
        @(negedge clk);
        guard++;
      end
    end
    check(opDone, "R9 done pulse seen", 80'(opDone), 80'(1));
    check(opData == expData, store ? "R9 store buffer" : "R3/R4/R9 load operand",
          opData, expData);
    check(xferCnt == expXfers, store ? "R5 write count" : "R4 read count",
          80'(xferCnt), 80'(expXfers));
    check(!busReq, "R7 bus released at done", 80'(busReq), 80'(0));
    @(negedge clk);
    check(!opDone, "R9 done is one cycle", 80'(opDone), 80'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busReq && !mRd && !mWr && !opDone, "R1 outputs idle in reset",
          80'({busReq, mRd, mWr, opDone}), 80'(0));
    rstN = 1'b1;
    @(negedge clk);
    check(!busReq && !mRd && !mWr && !opDone, "R1 outputs idle after reset",
          80'({busReq, mRd, mWr, opDone}), 80'(0));

    // R10: host read with nothing pending
    hostAddr = 20'h01234;
    hostData = 16'hBEEF;
    hostRd = 1'b1;
    hostDone = 1'b1;
    @(negedge clk);
    hostRd = 1'b0;
    hostDone = 1'b0;
    reqSeen = 1'b0;
    for (int k = 0; k < 4; k++) begin
      check(!busReq && !opDone && !reqSeen, "R10 stray host read ignored",
            80'({busReq, opDone}), 80'(0));
      @(negedge clk);
    end

    for (int d = 0; d < 2; d++) begin
      for (int b = 0; b < 3; b++) begin
        for (int w = 0; w < 4; w++) begin
          for (int s = 0; s < 2; s++) begin
            automatic int words = (w == 0) ? 1 : (w == 1) ? 2 : (w == 2) ? 4 : 5;
            automatic logic [19:0] base = (b == 0) ? 20'h00100 :
                                          (b == 1) ? 20'h7A3C4 : 20'hFFFFA;
            gntDelay = d * 3;
            waitCfg  = d * 2;
            runOp(words, s[0], base);
          end
        end
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule